// File: doc/BRIEF.md
# Two-Phase Iterative Integer Square Root

This unit takes a 16-bit unsigned number and returns its integer square root, the largest 8-bit value whose square does not exceed the input. It works one result bit at a time, from the most significant bit down. Each result bit needs two dependent arithmetic steps, so each bit is handled over two clock cycles.

In the first cycle of a bit, the unit adds the current trial bit to the partial result and stores the sum in a temporary register. In the same cycle it shifts the partial result right by one place. In the second cycle, it subtracts that temporary value from the remaining number. If the trial is accepted, the unit keeps the difference and sets the trial bit in the result. The trial bit is not held in its own shift register: it is decoded from the step counter.

The caller pulses `start` while the unit is idle. The unit then spends one cycle loading, sixteen cycles iterating and one cycle finishing. A one-cycle `done` pulse marks the point at which `root` becomes valid. `root` then keeps its value until the next result is ready.

Top module: `sqrt_iter`

## Requirements
- R1: While reset is held and directly after it, `busy`, `done` and `root` are all 0.
- R2: A `start` sampled high while `busy` is 0 is accepted, and `busy` reads 1 after that clock edge.
- R3: For an accepted start sampled at edge E0, `done` is 0 after edges E1 to E16, is 1 for exactly one cycle after edge E17 (18 cycles in all: load, 16 iteration cycles, finish), and is 0 again after E18. `busy` is 1 after E1 to E16 and 0 when `done` is 1.
- R4: When `done` is 1, `root` equals floor(sqrt(value)), where value is the input sampled with the accepted start. This holds over the whole 16-bit range, including inputs with bit 15 set.
- R5: The two range ends are exact: input 0xFFFF gives `root` 255, and input 0 gives `root` 0.
- R6: A `start` or `value` change while `busy` is 1 has no effect. The pending result and its timing are unchanged.
- R7: `root` holds its value from one `done` pulse until the next.
- R8: A `start` given in the same cycle in which `done` is 1 is accepted, and it produces a correct result with the timing of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a root; honoured only when idle |
| value | input | 16 | Unsigned number, sampled with an accepted start |
| busy | output | 1 | High while a computation is in progress |
| done | output | 1 | One-cycle pulse when `root` is newly valid |
| root | output | 8 | Integer square root of the last accepted input |

## Verification
The bench tests several groups of inputs:
- Perfect squares and the values directly next to them. These show whether each trial bit is accepted or rejected at the exact boundary.
- The two range ends and values with bit 15 set. These show whether the acceptance test handles a working number that is negative when read as a signed value, which a plain sign test would get wrong.
- A strided sweep across the full range. This catches a mis-decoded trial bit at any step position.
- A start pulse during a computation and a start pulse in the done cycle. These separate the rule that ignores requests while busy from the rule that allows back-to-back operation.

// File: rtl/sqrt_iter.sv
module sqrt_iter #(
  parameter int WIDTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   value,
  output logic               busy,
  output logic               done,
  output logic [WIDTH/2-1:0] root
);
  localparam int RW = WIDTH / 2;
  localparam int CW = $clog2(WIDTH);
  localparam int LW = $clog2(WIDTH + 2) + 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;

  state_t           state;
  logic [CW-1:0]    cnt;
  logic [WIDTH-1:0] num, res, tmp, mask, diff;
  logic             accept;

  always_comb begin
    mask = '0;
    mask[WIDTH - 2 - 2 * int'(cnt[CW-1:1])] = 1'b1;
  end

  assign diff   = num - tmp;
  assign accept = !diff[WIDTH-1] || num[WIDTH-1];
  assign busy   = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      num   <= '0;
      res   <= '0;
      tmp   <= '0;
      done  <= 1'b0;
      root  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state <= S_RUN;
          cnt   <= '0;
          num   <= value;
          res   <= '0;
        end
        S_RUN: begin
          cnt <= cnt + 1'b1;
          if (!cnt[0]) begin
            tmp <= res + mask;
            res <= res >> 1;
          end else if (accept) begin
            num <= diff;
            res <= res + mask;
          end
          if (cnt == CW'(WIDTH - 1)) state <= S_FIN;
        end
        default: begin
          state <= S_IDLE;
          root  <= res[RW-1:0];
          done  <= 1'b1;
        end
      endcase
    end
  end

  logic [LW-1:0] lat;
  always_ff @(posedge clk) begin
    if (!rst_n)                   lat <= '0;
    else if (state == S_IDLE)     lat <= '0;
    else                          lat <= lat + 1'b1;
  end

  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r3_no_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(lat) == LW'(WIDTH));
  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  a_r7_root_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(root));
  a_r4_num_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && cnt[0] && accept) |=> num == $past(diff));
endmodule

// File: tb/test_sqrt_iter.sv
module test_sqrt_iter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] value = '0;
  logic        busy, done;
  logic [7:0]  root;
  int          n_checks = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  sqrt_iter #(.WIDTH(16)) i_sqrt_iter (
    .clk(clk), .rst_n(rst_n), .start(start), .value(value),
    .busy(busy), .done(done), .root(root)
  );

  function automatic int isqrt(int v);
    int r = 0;
    while ((r + 1) * (r + 1) <= v) r++;
    return r;
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [15:0] v, input bit disturb);
    @(negedge clk);
    start = 1'b1;
    value = v;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after accept", busy, 1);
    for (int i = 1; i <= 16; i++) begin
      if (disturb && i == 5) begin
        start = 1'b1;
        value = ~v;
      end
      if (disturb && i == 6) start = 1'b0;
      @(negedge clk);
      if (i == 16) begin
        check("R3 no early done", done, 0);
        check("R3 busy before done", busy, 1);
      end
    end
    @(negedge clk);
    check("R3 done pulse", done, 1);
    check("R3 idle at done", busy, 0);
    check(disturb ? "R6 root unaffected" : "R4 root", root, isqrt(int'(v)));
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 root", root, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after release", busy, 0);
  endtask

  task automatic t_ends;
    run_one(16'hFFFF, 0);
    check("R5 max", root, 255);
    @(negedge clk);
    check("R3 done drops", done, 0);
    check("R7 root holds", root, 255);
    run_one(16'h0000, 0);
    check("R5 zero", root, 0);
  endtask

  task automatic t_squares;
    int vals[14] = '{1, 2, 3, 4, 8, 15, 16, 17, 255, 256, 16383, 16384, 32768, 65025};
    foreach (vals[k]) run_one(16'(vals[k]), 0);
    run_one(16'd65024, 0);
    run_one(16'hFFFE, 0);
    run_one(16'h8001, 0);
  endtask

  task automatic t_sweep;
    for (int v = 3; v < 65536; v += 257) run_one(16'(v), 0);
  endtask

  task automatic t_busy_start;
    run_one(16'd1000, 1);
    repeat (4) @(negedge clk);
    check("R6 no spurious start", busy, 0);
    check("R7 root holds idle", root, 31);
  endtask

  task automatic t_back_to_back;
    run_one(16'd50000, 0);
    start = 1'b1;
    value = 16'd81;
    @(negedge clk);
    start = 1'b0;
    check("R8 accepted in done cycle", busy, 1);
    repeat (16) @(negedge clk);
    check("R8 no early done", done, 0);
    @(negedge clk);
    check("R8 done", done, 1);
    check("R8 root", root, 9);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_ends();
        t_squares();
        t_sweep();
        t_busy_start();
        t_back_to_back();
      end
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule